// File: doc/BRIEF.md
# Leading Zero Count Unit

This unit takes a 64-bit general-purpose operand and reports how many zero bits lead it. The count starts at the most significant bit of a chosen operand size of 16, 32 or 64 bits. It also produces three condition flags. A zero operand has a defined result: the count is then the full operand width, never an undefined value. One flag reports that the operand was zero and a second reports that the count itself is zero. The overflow flag carries no information.

An execution pipeline presents an operand, a size code and a one-cycle strobe. One clock later the unit returns the count, zero-extended to 64 bits, with the flags and a one-cycle result strobe. It accepts a new operand on every cycle. Operand bits above the selected size do not affect the result. Between strobes the last result and its flags stay on the outputs.

Top module: `lzc_unit`

## Requirements
- R1: For a nonzero field, `count_o` is the number of consecutive zero bits starting at the field's top bit (bit W-1, where W is the selected width) and running downward.
- R2: When every bit of the selected field is zero, `count_o` equals W (16, 32 or 64).
- R3: `cf_o` is 1 exactly when the selected field is all zero.
- R4: `zf_o` is 1 exactly when `count_o` is 0, which means bit W-1 of the operand is 1.
- R5: `of_o` is 0 after every operation.
- R6: Bits of `src_i` at positions W and above do not change any output. `count_o` bits above the count's own width read 0.
- R7: Size code `size_i` 2'b00 selects W=16, 2'b01 selects W=32, and both 2'b10 and 2'b11 select W=64.
- R8: Result and flags appear on the first rising edge after the edge that samples `in_valid_i`=1. `out_valid_o` is then high for exactly that one cycle per accepted strobe. Back-to-back strobes give back-to-back results. Without a strobe, `count_o`, `zf_o` and `cf_o` hold their values.
- R9: While synchronous active-high `rst_i` is 1, `count_o`, `zf_o`, `cf_o`, `of_o` and `out_valid_o` are driven to 0 from the next edge onward, whatever `in_valid_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Operand strobe |
| src_i | input | 64 | Source operand |
| size_i | input | 2 | Operand size code (see R7) |
| out_valid_o | output | 1 | Result strobe, one cycle |
| count_o | output | 64 | Leading zero count, zero-extended |
| zf_o | output | 1 | Count-is-zero flag |
| cf_o | output | 1 | Source-is-zero flag |
| of_o | output | 1 | Overflow flag, always 0 |

## Verification
A single one-bit walked across every position of each width shows that the count follows the bit position exactly, including across the 8-bit group boundaries of the scan. All-ones and all-zero fields isolate the two flag extremes: a count of zero raises the zero flag, and an empty field raises the carry flag with the full-width count. Operands whose upper bits are set above a zero or sparse field separate correct masking from a scan that leaks into the ignored bits, and the spare size code 2'b11 is checked against 64-bit treatment. Pseudo-random operands sent back to back, followed by idle cycles with changing inputs, separate one-cycle latency and result holding from designs that load or pulse at the wrong time.

// File: rtl/lzc_pkg.sv
package lzc_pkg;

  localparam int unsigned LZC_DATA_W  = 64;
  localparam int unsigned LZC_GROUP_W = 8;

  // Size code to examined operand width. Codes 2'b10 and 2'b11 both mean full width.
  function automatic int unsigned op_width(input logic [1:0] sz, input int unsigned dw);
    case (sz)
      2'b00:   return dw / 4;
      2'b01:   return dw / 2;
      default: return dw;
    endcase
  endfunction

endpackage

// File: rtl/lzc_align.sv
// Places the selected field at the top of the vector and fills the vacated low bits with zeros.
module lzc_align #(
  parameter int unsigned DATA_W = lzc_pkg::LZC_DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] aligned_o,
  output logic [CNT_W-1:0]  width_o
);
  localparam int unsigned QTR = DATA_W / 4;
  localparam int unsigned HLF = DATA_W / 2;

  always_comb begin
    case (size_i)
      2'b00:   aligned_o = {src_i[QTR-1:0], {(DATA_W-QTR){1'b0}}};
      2'b01:   aligned_o = {src_i[HLF-1:0], {(DATA_W-HLF){1'b0}}};
      default: aligned_o = src_i;
    endcase
    width_o = CNT_W'(lzc_pkg::op_width(size_i, DATA_W));
  end

endmodule

// File: rtl/lzc_group_scan.sv
// Two-level leading zero scan: a local count inside each group, then the first nonzero group wins.
module lzc_group_scan #(
  parameter int unsigned DATA_W  = lzc_pkg::LZC_DATA_W,
  parameter int unsigned GROUP_W = lzc_pkg::LZC_GROUP_W,
  localparam int unsigned CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] vec_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              all_zero_o
);
  localparam int unsigned NGRP   = DATA_W / GROUP_W;
  localparam int unsigned GIDX_W = $clog2(GROUP_W);

  function automatic logic [GIDX_W-1:0] group_lz(input logic [GROUP_W-1:0] g);
    logic [GIDX_W-1:0] n;
    logic              hit;
    n   = '0;
    hit = 1'b0;
    for (int b = GROUP_W - 1; b >= 0; b--) begin
      if (!hit) begin
        if (g[b]) hit = 1'b1;
        else      n = n + GIDX_W'(1);
      end
    end
    return n;
  endfunction

  logic [NGRP-1:0]   grp_nz;
  logic [GIDX_W-1:0] grp_lz [NGRP];

  // Group 0 holds the most significant bits.
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GROUP_W-1:0] bits;
    assign bits      = vec_i[DATA_W-1-g*GROUP_W -: GROUP_W];
    assign grp_nz[g] = |bits;
    assign grp_lz[g] = group_lz(bits);
  end

  always_comb begin
    count_o    = CNT_W'(DATA_W);
    all_zero_o = 1'b1;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (grp_nz[g]) begin
        count_o    = CNT_W'(g * GROUP_W) + CNT_W'(grp_lz[g]);
        all_zero_o = 1'b0;
      end
    end
  end

endmodule

// File: rtl/lzc_flags.sv
// Final count and condition flags from the raw scan.
module lzc_flags #(
  parameter int unsigned DATA_W = lzc_pkg::LZC_DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1
) (
  input  logic [CNT_W-1:0] raw_count_i,
  input  logic             field_zero_i,
  input  logic [CNT_W-1:0] width_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zf_o,
  output logic             cf_o,
  output logic             of_o
);
  always_comb begin
    count_o = field_zero_i ? width_i : raw_count_i;
    cf_o    = field_zero_i;
    zf_o    = (count_o == '0);
    of_o    = 1'b0;
  end

endmodule

// File: rtl/lzc_unit.sv
module lzc_unit #(
  parameter int unsigned DATA_W  = lzc_pkg::LZC_DATA_W,
  parameter int unsigned GROUP_W = lzc_pkg::LZC_GROUP_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        size_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] count_o,
  output logic              zf_o,
  output logic              cf_o,
  output logic              of_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] aligned_w;
  logic [CNT_W-1:0]  width_w;
  logic [CNT_W-1:0]  raw_count_w;
  logic              field_zero_w;
  logic [CNT_W-1:0]  count_w;
  logic              zf_w, cf_w, of_w;
  logic              load_w;

  logic [CNT_W-1:0]  cnt_q;
  logic              zf_q, cf_q, of_q, vld_q;

  assign load_w = in_valid_i;

  lzc_align #(.DATA_W(DATA_W)) u_align (
    .src_i    (src_i),
    .size_i   (size_i),
    .aligned_o(aligned_w),
    .width_o  (width_w)
  );

  lzc_group_scan #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) u_scan (
    .vec_i     (aligned_w),
    .count_o   (raw_count_w),
    .all_zero_o(field_zero_w)
  );

  lzc_flags #(.DATA_W(DATA_W)) u_flags (
    .raw_count_i (raw_count_w),
    .field_zero_i(field_zero_w),
    .width_i     (width_w),
    .count_o     (count_w),
    .zf_o        (zf_w),
    .cf_o        (cf_w),
    .of_o        (of_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      zf_q  <= 1'b0;
      cf_q  <= 1'b0;
      of_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= load_w;
      if (load_w) begin
        cnt_q <= count_w;
        zf_q  <= zf_w;
        cf_q  <= cf_w;
        of_q  <= of_w;
      end
    end
  end

  assign out_valid_o = vld_q;
  assign count_o     = DATA_W'(cnt_q);
  assign zf_o        = zf_q;
  assign cf_o        = cf_q;
  assign of_o        = of_q;

endmodule

// File: rtl/lzc_unit_chk.sv
module lzc_unit_chk #(
  parameter int unsigned DATA_W = lzc_pkg::LZC_DATA_W
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              in_valid_i,
  input logic [1:0]        size_i,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] count_o,
  input logic              zf_o,
  input logic              cf_o,
  input logic              of_o
);

  a_r8_result_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |=> out_valid_o);

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> !out_valid_o);

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> ($stable(count_o) && $stable(zf_o) && $stable(cf_o)));

  a_r2_zero_gives_width: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && cf_o) |-> (count_o == DATA_W'(lzc_pkg::op_width($past(size_i), DATA_W))));

  a_r1_count_bounded: assert property (@(posedge clk_i) disable iff (rst_i)
    out_valid_o |-> (count_o <= DATA_W'(lzc_pkg::op_width($past(size_i), DATA_W))));

  a_r3_cf_only_at_width: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && !cf_o) |-> (count_o < DATA_W'(lzc_pkg::op_width($past(size_i), DATA_W))));

  a_r4_zf_vs_count: assert property (@(posedge clk_i) disable iff (rst_i)
    out_valid_o |-> (zf_o == (count_o == '0)));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (rst_i)
    out_valid_o |-> !of_o);

  a_r9_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (!out_valid_o && count_o == '0 && !zf_o && !cf_o && !of_o));

endmodule

bind lzc_unit lzc_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .in_valid_i (in_valid_i),
  .size_i     (size_i),
  .out_valid_o(out_valid_o),
  .count_o    (count_o),
  .zf_o       (zf_o),
  .cf_o       (cf_o),
  .of_o       (of_o)
);

// File: tb/test_lzc_unit.sv
module test_lzc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src = '0;
  logic [1:0]  size = 2'b00;
  logic        out_valid;
  logic [63:0] count;
  logic        zf, cf, of;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] cnt;
    logic        zf;
    logic        cf;
  } exp_t;

  exp_t exp_q[$];
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #10 clk = ~clk;  // 50 MHz

  lzc_unit i_lzc_unit (
    .clk_i      (clk),
    .rst_i      (rst),
    .in_valid_i (in_valid),
    .src_i      (src),
    .size_i     (size),
    .out_valid_o(out_valid),
    .count_o    (count),
    .zf_o       (zf),
    .cf_o       (cf),
    .of_o       (of)
  );

  // R7: size code to width, restated here
  function automatic int bench_width(input logic [1:0] sz);
    if (sz == 2'b00) return 16;
    if (sz == 2'b01) return 32;
    return 64;
  endfunction

  // Walk downward from the field's top bit (R1, R2)
  function automatic int bench_lz(input logic [63:0] v, input int w);
    int n = 0;
    for (int i = w - 1; i >= 0; i--) begin
      if (v[i]) break;
      n++;
    end
    return n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [63:0] v, input logic [1:0] sz);
    exp_t e;
    int   w;
    int   n;
    @(negedge clk);
    in_valid = 1'b1;
    src      = v;
    size     = sz;
    w        = bench_width(sz);
    n        = bench_lz(v, w);
    e.cnt    = 64'(n);
    e.cf     = (n == w);
    e.zf     = (n == 0);
    exp_q.push_back(e);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src      = ~src ^ 64'h00FF_00FF_00FF_00FF;
      size     = size + 2'b01;
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  // Monitor: compare each produced result with the oldest expected item
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R8 unexpected out_valid actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.cf ? "R2 count" : "R1 count", count, e.cnt);
        check("R3 cf", 64'(cf), 64'(e.cf));
        check("R4 zf", 64'(zf), 64'(e.zf));
        check("R5 of", 64'(of), 64'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    // R9: strobes during reset must leave outputs cleared
    in_valid = 1'b1;
    src      = 64'h1;
    repeat (3) @(negedge clk);
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R9 count", count, 64'd0);
    check("R9 flags", {61'd0, zf, cf, of}, 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;

    // R1, R4: single one walked through every position of each width
    for (int s = 0; s < 3; s++) begin
      for (int b = 0; b < bench_width(2'(s)); b++) send(64'd1 << b, 2'(s));
    end
    // R2, R3: empty fields; R4: top bit set
    for (int s = 0; s < 4; s++) begin
      send(64'd0, 2'(s));
      send('1, 2'(s));
    end
    // R6: upper bits set above the selected field
    send(64'hFFFF_FFFF_FFFF_0000, 2'b00);
    send(64'hFFFF_FFFF_0000_0000, 2'b01);
    send(64'hA5A5_A5A5_0000_0100, 2'b00);
    send(64'h8000_0000_0004_0000, 2'b01);
    // R7: spare code 2'b11 behaves as 64-bit
    send(64'h0000_0001_0000_0000, 2'b11);
    send(64'h0000_0000_0000_8000, 2'b11);
    idle(3);
    // Pseudo-random operands, back to back, then with gaps (R8)
    for (int i = 0; i < 60; i++) begin
      lfsr = next_rand(lfsr);
      send(lfsr >> (i % 64), 2'(i % 4));
      if (i % 7 == 0) idle(1);
    end
    idle(3);
    check("R8 queue drained", 64'(exp_q.size()), 64'd0);

    // R8: result holds through idle cycles with changing inputs
    send(64'h0000_0000_0001_0000, 2'b10);
    idle(1);
    idle(4);
    held = count;
    check("R8 hold count", held, 64'd47);
    check("R8 no pulse", 64'(out_valid), 64'd0);
    check("R6 upper count bits", {count[63:7], 7'd0}, 64'd0);

    // R9: reset mid-stream clears outputs
    send(64'h1, 2'b00);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    void'(exp_q.pop_front());
    @(negedge clk);
    check("R9 mid reset count", count, 64'd0);
    check("R9 mid reset valid", 64'(out_valid), 64'd0);
    rst = 1'b0;
    idle(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule